// File: doc/BRIEF.md
# Split Work-RAM Protection Unit

This unit guards a 1 KB on-chip work RAM that the CPU sees through the 4 KB window 0x7000–0x7FFF. The window repeats the RAM every 1 KB, and each copy is split into a lower 512-byte half and an upper 512-byte half. A global enable bit and four per-half permission bits decide how each half behaves. A half can be readable, writable, forced to read as zero, or left undriven so that the data bus keeps its previous value.

Two strobes load the permission state from the CPU write-data bus. The index strobe carries the global enable. The control strobe carries the per-half read and write permissions. For each CPU access, the unit decodes the address against the window and the current permissions in the same cycle. From that it produces the RAM chip-select, the RAM write-enable, a read-as-zero flag and an open-bus flag. The unit contains the RAM array itself. Its read-data output is registered and changes in the cycle after a read. A normal read loads the stored byte, a zero-forced read loads zero, and an open-bus read leaves the output unchanged.

Top module: `wram_guard`

## Requirements
- R1: After a synchronous active-low reset, both permission registers are zero and `rd_data` is zero. A read anywhere in the window then raises `open_bus` and leaves `ram_cs` low.
- R2: An access whose address lies outside 0x7000–0x7FFF keeps `ram_cs`, `ram_we`, `rd_zero` and `open_bus` low and leaves `rd_data` unchanged.
- R3: When the global enable (index register bit 5) is clear, every read in the window raises `open_bus`, and no write in the window raises `ram_we`.
- R4: Address bit 9 selects the half (0 is lower, 1 is upper). The RAM cell used is address bits 9:0, so all four 1 KB copies of the window reach the same bytes.
- R5: With the global enable set and neither half read-enabled, reads of either half raise `open_bus`.
- R6: With the global enable set and exactly one half read-enabled, a read of the other half raises `rd_zero`, keeps `ram_cs` low, and loads zero into `rd_data` in the next cycle.
- R7: The control register holds four permission bits: bit 5 is lower-half read, bit 4 is lower-half write, bit 7 is upper-half read and bit 6 is upper-half write. A write raises `ram_we` (and `ram_cs`) only when the global enable, that half's read bit and that half's write bit are all set. A blocked write leaves the RAM unchanged.
- R8: A read of a readable half raises `ram_cs` and loads the stored byte into `rd_data` one cycle later. An open-bus read leaves `rd_data` unchanged.
- R9: The permission registers change only when their own strobe is high. Bits other than the five named ones have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data; also the source for register loads |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| idx_we | input | 1 | Load the index register (global enable) from `cpu_wdata` |
| ctl_we | input | 1 | Load the control register (per-half permissions) from `cpu_wdata` |
| ram_cs | output | 1 | RAM selected for this access |
| ram_we | output | 1 | RAM written this cycle |
| rd_zero | output | 1 | Current read returns zero |
| open_bus | output | 1 | Current read leaves the bus undriven |
| rd_data | output | 8 | Registered read data |

## Verification
The assertions assume that `cpu_rd` and `cpu_wr` are never high together. Within a read, they also assume that `cpu_addr` is held steady for the cycle in which the flags are judged. The stimulus keeps to this: it issues one access at a time, each for a single cycle, followed by an idle cycle. Register loads are never overlapped with the read whose result they would change. Each read's expected byte is queued from a separate model of the permission bits and a shadow copy of the RAM, and the queue is drained when the registered output appears.

// File: rtl/wram_guard_pkg.sv
// Shared constants and types for the split work-RAM protection unit.
// Assumes an 8-bit or wider register data path: permission bits sit at 4..7.
package wram_guard_pkg;
    localparam int MASTER_BIT = 5;
    localparam int LO_RD_BIT  = 5;
    localparam int LO_WR_BIT  = 4;
    localparam int HI_RD_BIT  = 7;
    localparam int HI_WR_BIT  = 6;
    localparam int NUM_HALVES = 2;

    // What the read-data register does with the current access.
    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_RAM  = 2'd1,
        RD_ZERO = 2'd2,
        RD_HOLD = 2'd3
    } rd_mode_e;

    typedef struct packed {
        logic                  master;
        logic [NUM_HALVES-1:0] rd_en;
        logic [NUM_HALVES-1:0] wr_en;
    } prot_t;

    function automatic int rd_bit_of(input int h);
        return (h == 0) ? LO_RD_BIT : HI_RD_BIT;
    endfunction

    function automatic int wr_bit_of(input int h);
        return (h == 0) ? LO_WR_BIT : HI_WR_BIT;
    endfunction
endpackage

// File: rtl/wram_ctl_regs.sv
// Holds the index and control registers and extracts the protection bits.
// Assumes DATA_W >= 8. Registers load only on their own strobe.
module wram_ctl_regs
    import wram_guard_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_we,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] wdata,
    output prot_t             prot
);
    logic [DATA_W-1:0]     idx_q;
    logic [DATA_W-1:0]     ctl_q;
    logic [NUM_HALVES-1:0] rd_v;
    logic [NUM_HALVES-1:0] wr_v;
    logic                  unused_regbits;

    // Index register: loads on idx_we, clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_we) idx_q <= wdata;
    end

    // Control register: loads on ctl_we, clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_we) ctl_q <= wdata;
    end

    // Per-half permission extraction.
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        assign rd_v[h] = ctl_q[rd_bit_of(h)];
        assign wr_v[h] = ctl_q[wr_bit_of(h)];
    end

    // Pack the protection state.
    always_comb begin
        prot.master = idx_q[MASTER_BIT];
        prot.rd_en  = rd_v;
        prot.wr_en  = wr_v;
    end

    assign unused_regbits = ^{idx_q, ctl_q};
endmodule

// File: rtl/wram_access_decode.sv
// Decodes one CPU access against the mirrored window and the protection bits.
// Purely combinational. Assumes read and write strobes are not both high.
module wram_access_decode
    import wram_guard_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int WIN_AW  = 12,
    parameter int WIN_TAG = 7,
    parameter int RAM_AW  = 10
) (
    input  logic              [ADDR_W-1:0] addr,
    input  logic                           rd,
    input  logic                           wr,
    input  prot_t                          prot,
    output logic              [RAM_AW-1:0] ram_addr,
    output logic                           ram_cs,
    output logic                           ram_we,
    output logic                           rd_zero,
    output logic                           open_bus,
    output rd_mode_e                       mode
);
    localparam int TAG_W = ADDR_W - WIN_AW;

    logic                  in_win;
    logic                  half;
    logic                  any_rd;
    logic [NUM_HALVES-1:0] wr_ok;
    logic                  unused_mid;

    assign in_win     = (addr[ADDR_W-1:WIN_AW] == TAG_W'(WIN_TAG));
    assign half       = addr[RAM_AW-1];
    assign ram_addr   = addr[RAM_AW-1:0];
    assign any_rd     = |prot.rd_en;
    assign unused_mid = ^addr[WIN_AW-1:RAM_AW];

    // Write permission per half needs global, read and write bits together.
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_wok
        assign wr_ok[h] = prot.master & prot.rd_en[h] & prot.wr_en[h];
    end

    // Classify a read: undriven, zero or RAM data.
    always_comb begin
        if (!(in_win && rd))                 mode = RD_NONE;
        else if (!prot.master || !any_rd)    mode = RD_HOLD;
        else if (prot.rd_en[half])           mode = RD_RAM;
        else                                 mode = RD_ZERO;
    end

    // Strobes toward the RAM and the bus.
    always_comb begin
        ram_we   = in_win & wr & ~rd & wr_ok[half];
        ram_cs   = ram_we | (mode == RD_RAM);
        rd_zero  = (mode == RD_ZERO);
        open_bus = (mode == RD_HOLD);
    end
endmodule

// File: rtl/wram_array.sv
// Work RAM: synchronous write, combinational read. Contents are not reset.
module wram_array #(
    parameter int RAM_AW = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [RAM_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a byte when write-enabled.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/wram_read_path.sv
// Registered read-data: loads RAM data or zero, or holds for open bus.
module wram_read_path
    import wram_guard_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  rd_mode_e             mode,
    input  logic    [DATA_W-1:0] ram_rdata,
    output logic    [DATA_W-1:0] rd_data
);
    // Update the output register according to the read classification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            unique case (mode)
                RD_RAM:  rd_data <= ram_rdata;
                RD_ZERO: rd_data <= '0;
                default: rd_data <= rd_data;
            endcase
        end
    end
endmodule

// File: rtl/wram_guard.sv
// Top level of the split work-RAM protection unit: permission registers,
// access decode, RAM array and registered read path.
// Assumes cpu_rd and cpu_wr are mutually exclusive.
module wram_guard
    import wram_guard_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int WIN_AW  = 12,
    parameter int WIN_TAG = 7,
    parameter int RAM_AW  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              idx_we,
    input  logic              ctl_we,
    output logic              ram_cs,
    output logic              ram_we,
    output logic              rd_zero,
    output logic              open_bus,
    output logic [DATA_W-1:0] rd_data
);
    prot_t             prot;
    rd_mode_e          mode;
    logic [RAM_AW-1:0] ram_addr;
    logic [DATA_W-1:0] ram_rdata;

    wram_ctl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_we (idx_we),
        .ctl_we (ctl_we),
        .wdata  (cpu_wdata),
        .prot   (prot)
    );

    wram_access_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_AW  (WIN_AW),
        .WIN_TAG (WIN_TAG),
        .RAM_AW  (RAM_AW)
    ) u_dec (
        .addr     (cpu_addr),
        .rd       (cpu_rd),
        .wr       (cpu_wr),
        .prot     (prot),
        .ram_addr (ram_addr),
        .ram_cs   (ram_cs),
        .ram_we   (ram_we),
        .rd_zero  (rd_zero),
        .open_bus (open_bus),
        .mode     (mode)
    );

    wram_array #(.RAM_AW(RAM_AW), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (cpu_wdata),
        .rdata (ram_rdata)
    );

    wram_read_path #(.DATA_W(DATA_W)) u_rdp (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .ram_rdata (ram_rdata),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/wram_guard_chk.sv
// Property checker for wram_guard, attached by bind below.
module wram_guard_chk
    import wram_guard_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int WIN_AW  = 12,
    parameter int WIN_TAG = 7,
    parameter int RAM_AW  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input prot_t             prot,
    input logic              ram_cs,
    input logic              ram_we,
    input logic              rd_zero,
    input logic              open_bus,
    input logic [DATA_W-1:0] rd_data
);
    localparam int TAG_W = ADDR_W - WIN_AW;

    logic c_in_win;
    logic c_half;
    logic unused_c;

    assign c_in_win = (cpu_addr[ADDR_W-1:WIN_AW] == TAG_W'(WIN_TAG));
    assign c_half   = cpu_addr[RAM_AW-1];
    assign unused_c = ^{cpu_addr[WIN_AW-1:RAM_AW], cpu_addr[RAM_AW-2:0]};

    // R2
    outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !c_in_win |-> (!ram_cs && !ram_we && !rd_zero && !open_bus));

    // R3
    master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_in_win && cpu_rd && !prot.master) |-> (open_bus && !ram_cs));

    // R5
    neither_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_in_win && cpu_rd && prot.rd_en == '0) |-> open_bus);

    // R7
    we_needs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (prot.master && prot.rd_en[c_half] && prot.wr_en[c_half]));

    // R7
    we_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |-> !ram_we);

    // R6
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_zero && open_bus) && !(rd_zero && ram_cs));

    // R6
    zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_zero |=> (rd_data == '0));

    // R8
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_bus |=> $stable(rd_data));
endmodule

bind wram_guard wram_guard_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .WIN_AW  (WIN_AW),
    .WIN_TAG (WIN_TAG),
    .RAM_AW  (RAM_AW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_rd   (cpu_rd),
    .cpu_wr   (cpu_wr),
    .prot     (prot),
    .ram_cs   (ram_cs),
    .ram_we   (ram_we),
    .rd_zero  (rd_zero),
    .open_bus (open_bus),
    .rd_data  (rd_data)
);

// File: tb/tb_wram_guard.sv
// Scoreboard bench: access tasks check the same-cycle flags and queue the
// expected read byte; a monitor compares it when the registered output lands.
module tb_wram_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        idx_we = 1'b0;
    logic        ctl_we = 1'b0;
    logic        ram_cs, ram_we, rd_zero, open_bus;
    logic [7:0]  rd_data;

    always #5 clk = ~clk;

    wram_guard dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .idx_we(idx_we), .ctl_we(ctl_we),
        .ram_cs(ram_cs), .ram_we(ram_we), .rd_zero(rd_zero),
        .open_bus(open_bus), .rd_data(rd_data)
    );

    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] shadow [1024];
    logic [7:0] idx_m = '0;
    logic [7:0] ctl_m = '0;
    logic [7:0] last_m = '0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       pend = 1'b0;
    logic [7:0] mon_e;
    string      mon_t;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: one queued expectation per read, compared after the edge.
    always @(posedge clk) pend <= cpu_rd;
    always @(posedge clk) begin
        #2;
        if (pend && exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            check({mon_t, " rd_data"}, {24'd0, rd_data}, {24'd0, mon_e});
        end
    end

    task automatic set_idx(input logic [7:0] v);
        @(negedge clk); cpu_wdata = v; idx_we = 1'b1;
        @(negedge clk); idx_we = 1'b0; idx_m = v;
    endtask

    task automatic set_ctl(input logic [7:0] v);
        @(negedge clk); cpu_wdata = v; ctl_we = 1'b1;
        @(negedge clk); ctl_we = 1'b0; ctl_m = v;
    endtask

    // Driver: one access, flag check, expectation push, then idle.
    task automatic access(input bit is_rd, input logic [15:0] a,
                          input logic [7:0] d, input string req);
        logic inw, h, m, rl, rh, wl, wh, rdh, wrh, anyr;
        logic e_ob, e_z, e_rr, e_we, e_cs;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_rd = is_rd; cpu_wr = !is_rd;
        inw = (a[15:12] == 4'h7); h = a[9]; m = idx_m[5];
        rl = ctl_m[5]; wl = ctl_m[4]; rh = ctl_m[7]; wh = ctl_m[6];
        rdh = h ? rh : rl; wrh = h ? wh : wl; anyr = rl | rh;
        e_ob = is_rd & inw & (!m | !anyr);
        e_z  = is_rd & inw & m & anyr & !rdh;
        e_rr = is_rd & inw & m & rdh;
        e_we = !is_rd & inw & m & rdh & wrh;
        e_cs = e_we | e_rr;
        #1;
        check({req, " flags cs/we/zero/ob"}, {28'd0, ram_cs, ram_we, rd_zero, open_bus},
              {28'd0, e_cs, e_we, e_z, e_ob});
        if (is_rd) begin
            if (e_rr)     last_m = shadow[a[9:0]];
            else if (e_z) last_m = 8'h00;
            exp_q.push_back(last_m);
            tag_q.push_back(req);
        end else if (e_we) begin
            shadow[a[9:0]] = d;
        end
        @(negedge clk); cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 reset rd_data", {24'd0, rd_data}, 32'd0);
        // R1: after reset the window is open bus
        access(1, 16'h7000, 8'h00, "R1 read after reset");
        // R2: outside the window nothing happens
        access(1, 16'h6000, 8'h00, "R2 read below window");
        access(0, 16'h8000, 8'h77, "R2 write above window");
        // R3: global enable clear blocks writes even with full permissions
        set_ctl(8'hF0);
        access(0, 16'h7000, 8'h99, "R3 write master off");
        access(1, 16'h7200, 8'h00, "R3 read master off");
        // R4/R8: enable all, write through mirrors, read back through others
        set_idx(8'h20);
        access(0, 16'h7000, 8'h5A, "R8 write low");
        access(0, 16'h7200, 8'hA5, "R8 write high");
        access(0, 16'h7401, 8'h3C, "R4 write mirror");
        access(1, 16'h7C00, 8'h00, "R4 read low mirror");
        access(1, 16'h7A00, 8'h00, "R4 read high mirror");
        access(1, 16'h7001, 8'h00, "R4 read offset one");
        // R5/R8: neither half readable, output holds
        set_ctl(8'h50);
        access(1, 16'h7000, 8'h00, "R5 low neither readable");
        access(1, 16'h7300, 8'h00, "R5 high neither readable");
        access(0, 16'h7000, 8'h01, "R7 write without read bit");
        // R6: only low readable
        set_ctl(8'h20);
        access(1, 16'h7200, 8'h00, "R6 high reads zero");
        access(1, 16'h7000, 8'h00, "R6 low readable");
        access(0, 16'h7000, 8'h02, "R7 write without write bit");
        // R9: data on the bus without a strobe changes nothing
        access(0, 16'h6100, 8'hFF, "R9 stray write data");
        access(1, 16'h7200, 8'h00, "R9 control unchanged");
        // R7: low fully open, high write bit without read bit
        set_ctl(8'h70);
        access(0, 16'h7000, 8'h11, "R7 low write allowed");
        access(0, 16'h7200, 8'h22, "R7 high write blocked");
        set_ctl(8'hF0);
        access(1, 16'h7200, 8'h00, "R7 high unchanged");
        access(1, 16'h7000, 8'h00, "R7 low updated");
        // R6: only high readable
        set_ctl(8'h80);
        access(1, 16'h7100, 8'h00, "R6 low reads zero");
        access(1, 16'h7E00, 8'h00, "R6 high readable");
        // R9: index bits other than bit 5 do not enable
        set_idx(8'hDF);
        access(1, 16'h7200, 8'h00, "R9 other index bits");
        set_idx(8'h20);
        access(1, 16'h7200, 8'h00, "R9 index bit 5 again");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("R8 queue drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule